// File: doc/BRIEF.md
# Timestamp Event Capture Unit

The unit records the value of a free-running cycle counter at the moment a trigger arrives. The trigger is one of two sources, picked by software. The first is an asynchronous external request pin, which is synchronised and edge-detected, with the edge polarity set by a configuration bit. The second is an internal one-cycle pulse-per-second strobe. There is one capture channel.

Software uses a small 16-bit register port. It arms the unit through the configuration and status words. It polls the status word for a valid capture and then reads the stored count as two half-words. It acknowledges the capture by writing the status word back with the valid bit cleared. If a trigger arrives while a capture is still unread, a sticky error bit is set. An overwrite policy decides whether the stored count is kept or replaced in that case. An 8-bit sequence counter in the status word counts triggers, and any status write clears it.

Top module: `evt_stamp_capture`

## Requirements
- R1: After a synchronous active-low reset, all four register addresses read 0x0000.
- R2: With the pin source and rising-edge polarity, a 0-to-1 change on `req_pin` sets valid and stores `cycle_cnt`. This happens at the third clock edge at which the new pin level is present, and the stored value is `cycle_cnt` as sampled at that edge.
- R3: Configuration bit 2 set selects the falling edge of `req_pin` with the same latency. The opposite edge then captures nothing.
- R4: Status bit 2 set selects the strobe. A `pps_strobe` high at a clock edge captures `cycle_cnt` at that same edge, and pin edges are ignored. With status bit 2 clear, the strobe is ignored.
- R5: Status bit 0 (valid) is set by every capture. A status write with bit 0 clear clears it. A status write with bit 0 set leaves it unchanged.
- R6: Status bit 1 (error) is set when a trigger arrives while valid is set. It stays set until a status write with bit 1 clear.
- R7: Configuration bit 0 (overwrite) clear keeps the stored count when a trigger arrives while valid is set. With bit 0 set, the stored count is replaced.
- R8: Status bits 15:8 hold a sequence counter. It increments on each trigger while configuration bit 1 (count enable) is set, holds while that bit is clear, and saturates at 255.
- R9: Any write to the status address zeroes the sequence counter. A trigger in the same cycle as the write is applied after the write.
- R10: The register map is: address 0 configuration (bits 2:0 writable, other bits read 0), address 1 status, address 2 stored count bits 15:0, address 3 stored count bits 31:16. Writes to addresses 2 and 3 have no effect. Read data is combinational on `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cycle_cnt | input | 32 | Free-running cycle count to be captured |
| req_pin | input | 1 | Asynchronous external request input |
| pps_strobe | input | 1 | Internal one-cycle pulse-per-second strobe |
| reg_wr_en | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |

## Verification
The capture path is driven with single pin edges of each polarity against each edge setting. This shows that the latency is exactly three edges and that only the selected edge triggers. Strobe pulses are then given with each source setting, which separates the two trigger paths. Back-to-back triggers without an acknowledge, once with overwrite on and once with it off, separate the kept value from the replaced value and show the sticky error. A long run of strobes reaches counter saturation, a status write issued together with a trigger fixes the order of clear and count, and a long random mix of pin toggles, strobes and writes to every address is compared each cycle against a bench model.

// File: rtl/evt_cap_pkg.sv
// Package: shared register addresses, bit positions and the configuration
// record for the timestamp event capture unit.
package evt_cap_pkg;
    localparam int REG_W      = 16;
    localparam int ADDR_W     = 2;

    localparam logic [ADDR_W-1:0] ADDR_CFG    = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_TS_LO  = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_TS_HI  = 2'd3;

    // configuration word bit positions
    localparam int CFG_OVR_BIT  = 0;
    localparam int CFG_CNT_BIT  = 1;
    localparam int CFG_FALL_BIT = 2;
    localparam int CFG_BITS     = 3;

    // status word bit positions
    localparam int ST_VALID_BIT = 0;
    localparam int ST_ERR_BIT   = 1;
    localparam int ST_SEL_BIT   = 2;
    localparam int ST_LOW_BITS  = 3;

    typedef struct packed {
        logic falling;   // trigger on falling pin edge
        logic cnt_en;    // sequence counter runs
        logic ovr_en;    // new capture replaces unread one
    } cap_cfg_t;
endpackage

// File: rtl/evt_req_sync.sv
// Module: evt_req_sync
// Brings the asynchronous request pin into the clock domain through a chain
// of SYNC_STAGES flops and produces one-cycle rising and falling pulses from
// the synchronised level.
// Assumes: req_pin may change at any time; SYNC_STAGES >= 2.
module evt_req_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_pin,
    output logic rise_pulse,
    output logic fall_pulse
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    // Synchroniser chain, one flop per stage
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[0] <= 1'b0;
                else        chain_q[0] <= req_pin;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    end

    // Delayed copy of the synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[SYNC_STAGES-1];
    end

    // Edge pulses from synchronised level against its delayed copy
    always_comb begin
        rise_pulse = chain_q[SYNC_STAGES-1] & ~prev_q;
        fall_pulse = ~chain_q[SYNC_STAGES-1] & prev_q;
    end

    // a rise pulse can never be followed directly by another rise pulse
    assert_single_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse);
    assert_single_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fall_pulse |=> !fall_pulse);
endmodule

// File: rtl/evt_capture_core.sv
// Module: evt_capture_core
// Holds the stored count, the valid and error flags and the saturating
// sequence counter. A status write in the same cycle as a trigger is
// applied first, and the trigger is then applied to the result.
// Assumes: trig is a one-cycle synchronous pulse.
module evt_capture_core #(
    parameter int TS_W  = 32,
    parameter int SEQ_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trig,
    input  logic [TS_W-1:0] cycle_cnt,
    input  logic            ovr_en,
    input  logic            cnt_en,
    input  logic            stat_wr,
    input  logic            wr_valid,
    input  logic            wr_err,
    output logic            valid_q,
    output logic            err_q,
    output logic [SEQ_W-1:0] seq_q,
    output logic [TS_W-1:0] ts_q
);
    localparam logic [SEQ_W-1:0] SEQ_MAX = {SEQ_W{1'b1}};

    logic             valid_w;
    logic             err_w;
    logic [SEQ_W-1:0] seq_w;

    // State as seen after a software status write in this cycle
    always_comb begin
        valid_w = stat_wr ? (valid_q & wr_valid) : valid_q;
        err_w   = stat_wr ? (err_q & wr_err)     : err_q;
        seq_w   = stat_wr ? '0                   : seq_q;
    end

    // Flag update: capture sets valid, capture on valid sets error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            valid_q <= valid_w | trig;
            err_q   <= err_w | (trig & valid_w);
        end
    end

    // Stored count: taken when free, or when overwrite is allowed
    always_ff @(posedge clk) begin
        if (!rst_n)                            ts_q <= '0;
        else if (trig && (!valid_w || ovr_en)) ts_q <= cycle_cnt;
    end

    // Sequence counter: counts triggers while enabled, saturates
    always_ff @(posedge clk) begin
        if (!rst_n)                                 seq_q <= '0;
        else if (trig && cnt_en && seq_w != SEQ_MAX) seq_q <= seq_w + 1'b1;
        else                                        seq_q <= seq_w;
    end

    assert_capture_sets_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> valid_q);
    assert_error_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !stat_wr) |=> err_q);
    assert_keep_unread_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && trig && !ovr_en && !stat_wr) |=> $stable(ts_q));
    assert_seq_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q == SEQ_MAX && !stat_wr) |=> (seq_q == SEQ_MAX));
    assert_seq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !trig) |=> (seq_q == '0));
endmodule

// File: rtl/evt_reg_file.sv
// Module: evt_reg_file
// Register port: holds the configuration word and the source-select bit,
// decodes status writes for the capture core and multiplexes read data.
// Assumes: reads have no side effects; addresses 2 and 3 are read-only.
module evt_reg_file
    import evt_cap_pkg::*;
#(
    parameter int TS_W  = 32,
    parameter int SEQ_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output cap_cfg_t          cfg,
    output logic              src_pps,
    output logic              stat_wr,
    output logic              wr_valid,
    output logic              wr_err,
    input  logic              valid,
    input  logic              err,
    input  logic [SEQ_W-1:0]  seq,
    input  logic [TS_W-1:0]   ts
);
    localparam int PAD_W = REG_W - SEQ_W - ST_LOW_BITS;

    cap_cfg_t cfg_q;
    logic     sel_q;
    logic     cfg_wr;
    logic     unused_wdata;

    // Write decode
    always_comb begin
        cfg_wr   = wr_en && (addr == ADDR_CFG);
        stat_wr  = wr_en && (addr == ADDR_STATUS);
        wr_valid = wdata[ST_VALID_BIT];
        wr_err   = wdata[ST_ERR_BIT];
    end

    assign unused_wdata = ^wdata[REG_W-1:CFG_BITS];

    // Configuration word and source select storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            sel_q <= 1'b0;
        end else begin
            if (cfg_wr) begin
                cfg_q.ovr_en  <= wdata[CFG_OVR_BIT];
                cfg_q.cnt_en  <= wdata[CFG_CNT_BIT];
                cfg_q.falling <= wdata[CFG_FALL_BIT];
            end
            if (stat_wr) sel_q <= wdata[ST_SEL_BIT];
        end
    end

    assign cfg     = cfg_q;
    assign src_pps = sel_q;

    // Read data multiplexer
    always_comb begin
        case (addr)
            ADDR_CFG:    rdata = {{(REG_W-CFG_BITS){1'b0}}, cfg_q.falling,
                                  cfg_q.cnt_en, cfg_q.ovr_en};
            ADDR_STATUS: rdata = {seq, {PAD_W{1'b0}}, sel_q, err, valid};
            ADDR_TS_LO:  rdata = ts[REG_W-1:0];
            default:     rdata = ts[TS_W-1:REG_W];
        endcase
    end

    assert_cfg_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_CFG) |=>
        ({cfg_q.falling, cfg_q.cnt_en, cfg_q.ovr_en} == $past(wdata[CFG_BITS-1:0])));
    assert_sel_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == ADDR_STATUS) |=> $stable(sel_q));
endmodule

// File: rtl/evt_stamp_capture.sv
// Module: evt_stamp_capture (top)
// Single-channel timestamp capture: synchronised pin edge or internal
// strobe latches the cycle count; a 16-bit register port configures the
// unit and returns status and the stored count.
// Assumes: pps_strobe is synchronous to clk; TS_W equals two register words.
module evt_stamp_capture
    import evt_cap_pkg::*;
#(
    parameter int TS_W        = 32,
    parameter int SEQ_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TS_W-1:0]   cycle_cnt,
    input  logic              req_pin,
    input  logic              pps_strobe,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata
);
    logic             rise_pulse, fall_pulse, pin_evt, trig;
    cap_cfg_t         cfg;
    logic             src_pps, stat_wr, wr_valid, wr_err;
    logic             valid, err;
    logic [SEQ_W-1:0] seq;
    logic [TS_W-1:0]  ts;

    evt_req_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_pin    (req_pin),
        .rise_pulse (rise_pulse),
        .fall_pulse (fall_pulse)
    );

    // Trigger source and edge selection
    always_comb begin
        pin_evt = cfg.falling ? fall_pulse : rise_pulse;
        trig    = src_pps ? pps_strobe : pin_evt;
    end

    evt_capture_core #(.TS_W(TS_W), .SEQ_W(SEQ_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .cycle_cnt (cycle_cnt),
        .ovr_en    (cfg.ovr_en),
        .cnt_en    (cfg.cnt_en),
        .stat_wr   (stat_wr),
        .wr_valid  (wr_valid),
        .wr_err    (wr_err),
        .valid_q   (valid),
        .err_q     (err),
        .seq_q     (seq),
        .ts_q      (ts)
    );

    evt_reg_file #(.TS_W(TS_W), .SEQ_W(SEQ_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .cfg      (cfg),
        .src_pps  (src_pps),
        .stat_wr  (stat_wr),
        .wr_valid (wr_valid),
        .wr_err   (wr_err),
        .valid    (valid),
        .err      (err),
        .seq      (seq),
        .ts       (ts)
    );

    // strobe source selected: pin edges must not capture
    assert_pin_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (src_pps && !pps_strobe && !valid && !stat_wr) |=> !valid);
endmodule

// File: tb/evt_stamp_capture_tb_top.sv
// Bench: directed corner cases, then a seeded random mix, each cycle
// compared against a requirement-level model held in the bench.
module evt_stamp_capture_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cycle_cnt;
    logic        req_pin, pps_strobe, reg_wr_en;
    logic [1:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] cyc_val;

    // model state
    logic [2:0]  m_cfg;
    logic        m_valid, m_err, m_sel;
    logic [7:0]  m_seq;
    logic [31:0] m_ts;
    logic        m_p1, m_p2, m_p3;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_stamp_capture dut_i (
        .clk(clk), .rst_n(rst_n), .cycle_cnt(cycle_cnt), .req_pin(req_pin),
        .pps_strobe(pps_strobe), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [15:0] model_read(input logic [1:0] a);
        case (a)
            2'd0:    return {13'd0, m_cfg};
            2'd1:    return {m_seq, 5'd0, m_sel, m_err, m_valid};
            2'd2:    return m_ts[15:0];
            default: return m_ts[31:16];
        endcase
    endfunction

    task automatic model_reset();
        m_cfg = '0; m_valid = 0; m_err = 0; m_sel = 0; m_seq = '0; m_ts = '0;
        m_p1 = 0; m_p2 = 0; m_p3 = 0;
    endtask

    task automatic model_clk(input logic pin, input logic pps, input logic wr,
                             input logic [1:0] a, input logic [15:0] wd,
                             input logic [31:0] cyc);
        logic ev;
        logic [2:0] old_cfg;
        ev = m_sel ? pps : (m_cfg[2] ? (!m_p2 && m_p3) : (m_p2 && !m_p3));
        old_cfg = m_cfg;
        m_p3 = m_p2; m_p2 = m_p1; m_p1 = pin;
        if (wr && a == 2'd1) begin
            m_valid = m_valid & wd[0];
            m_err   = m_err & wd[1];
            m_sel   = wd[2];
            m_seq   = '0;
        end
        if (wr && a == 2'd0) m_cfg = wd[2:0];
        if (ev) begin
            if (m_valid) begin
                m_err = 1'b1;
                if (old_cfg[0]) m_ts = cyc;
            end else begin
                m_ts = cyc;
            end
            m_valid = 1'b1;
            if (old_cfg[1] && m_seq != 8'hFF) m_seq = m_seq + 8'd1;
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // one clock: inputs driven now, model updated at the edge, read checked after
    task automatic step(input logic pin, input logic pps, input logic wr,
                        input logic [1:0] a, input logic [15:0] wd, input string tag);
        req_pin = pin; pps_strobe = pps; reg_wr_en = wr; reg_addr = a; reg_wdata = wd;
        cycle_cnt = cyc_val;
        @(posedge clk);
        model_clk(pin, pps, wr, a, wd, cyc_val);
        cyc_val = cyc_val + 32'd1;
        @(negedge clk);
        chk(tag, {16'd0, reg_rdata}, {16'd0, model_read(a)});
    endtask

    task automatic idle(input int n, input logic pin, input string tag);
        for (int i = 0; i < n; i++) step(pin, 1'b0, 1'b0, 2'd1, 16'd0, tag);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [15:0] wd, input string tag);
        step(req_pin, 1'b0, 1'b1, a, wd, tag);
    endtask

    task automatic peek(input logic [1:0] a, input string tag, input logic [15:0] exp);
        reg_wr_en = 1'b0; reg_addr = a;
        #1;
        chk(tag, {16'd0, reg_rdata}, {16'd0, exp});
        chk(tag, {16'd0, exp}, {16'd0, model_read(a)});
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp_ts, first_ts;
        void'($urandom(32'd20240611));
        cyc_val = 32'h1234_5670;
        rst_n = 0; req_pin = 0; pps_strobe = 0; reg_wr_en = 0; reg_addr = 0;
        reg_wdata = 0; cycle_cnt = cyc_val;
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state on every address
        for (int a = 0; a < 4; a++) peek(a[1:0], "R1 reset value", 16'h0000);

        // R2 rising pin edge, exact latency
        wr_reg(2'd0, 16'h0002, "R10 cfg write");
        step(1'b1, 0, 0, 2'd1, 0, "R2 edge cycle 1");
        step(1'b1, 0, 0, 2'd1, 0, "R2 edge cycle 2");
        peek(2'd1, "R2 not yet valid", 16'h0000);
        exp_ts = cyc_val;
        step(1'b1, 0, 0, 2'd1, 0, "R2 edge cycle 3");
        peek(2'd1, "R2 valid after third edge", 16'h0101);
        peek(2'd2, "R2 stored low", exp_ts[15:0]);
        peek(2'd3, "R2 stored high", exp_ts[31:16]);

        // R5/R9 acknowledge
        wr_reg(2'd1, 16'h0000, "R5 ack");
        peek(2'd1, "R5 R9 ack clears valid and seq", 16'h0000);

        // R3 falling edge
        wr_reg(2'd0, 16'h0006, "R10 cfg falling");
        step(1'b0, 0, 0, 2'd1, 0, "R3 fall 1");
        step(1'b0, 0, 0, 2'd1, 0, "R3 fall 2");
        exp_ts = cyc_val;
        step(1'b0, 0, 0, 2'd1, 0, "R3 fall 3");
        peek(2'd1, "R3 falling edge captures", 16'h0101);
        peek(2'd2, "R3 stored low", exp_ts[15:0]);
        wr_reg(2'd1, 16'h0000, "R5 ack");
        idle(6, 1'b1, "R3 rising ignored");
        peek(2'd1, "R3 rising edge ignored", 16'h0000);
        idle(4, 1'b0, "R3 settle");
        wr_reg(2'd1, 16'h0000, "R5 ack");

        // R4 strobe source
        wr_reg(2'd0, 16'h0002, "R10 cfg rising");
        wr_reg(2'd1, 16'h0004, "R4 select strobe");
        exp_ts = cyc_val;
        step(req_pin, 1'b1, 0, 2'd1, 0, "R4 strobe");
        peek(2'd1, "R4 strobe captures", 16'h0105);
        peek(2'd3, "R4 stored high", exp_ts[31:16]);
        peek(2'd2, "R4 stored low same edge", exp_ts[15:0]);
        wr_reg(2'd1, 16'h0004, "R5 ack keep sel");
        idle(5, 1'b1, "R4 pin ignored");
        idle(5, 1'b0, "R4 pin ignored");
        peek(2'd1, "R4 pin ignored under strobe", 16'h0004);
        wr_reg(2'd1, 16'h0000, "R4 back to pin");
        step(req_pin, 1'b1, 0, 2'd1, 0, "R4 strobe ignored");
        peek(2'd1, "R4 strobe ignored under pin", 16'h0000);

        // R6/R7 no overwrite
        wr_reg(2'd1, 16'h0004, "R4 select strobe");
        wr_reg(2'd0, 16'h0000, "R7 overwrite off");
        first_ts = cyc_val;
        step(req_pin, 1'b1, 0, 2'd1, 0, "R7 first");
        idle(3, req_pin, "R7 gap");
        step(req_pin, 1'b1, 0, 2'd1, 0, "R7 second");
        peek(2'd1, "R6 error on unread capture", 16'h0007);
        peek(2'd2, "R7 kept first low", first_ts[15:0]);
        wr_reg(2'd1, 16'h0007, "R6 write ones");
        peek(2'd1, "R6 error stays on write 1", 16'h0007);
        wr_reg(2'd1, 16'h0005, "R6 clear error");
        peek(2'd1, "R6 error cleared", 16'h0005);
        wr_reg(2'd0, 16'h0001, "R7 overwrite on");
        exp_ts = cyc_val;
        step(req_pin, 1'b1, 0, 2'd1, 0, "R7 replace");
        peek(2'd2, "R7 replaced low", exp_ts[15:0]);
        peek(2'd1, "R6 error set under overwrite", 16'h0007);

        // R8 saturation
        wr_reg(2'd0, 16'h0003, "R8 count on");
        wr_reg(2'd1, 16'h0004, "R9 clear");
        for (int i = 0; i < 260; i++) step(req_pin, 1'b1, 0, 2'd1, 0, "R8 counting");
        peek(2'd1, "R8 saturated at 255", 16'hFF07);
        wr_reg(2'd0, 16'h0001, "R8 count off");
        wr_reg(2'd1, 16'h0004, "R9 clear");
        for (int i = 0; i < 3; i++) step(req_pin, 1'b1, 0, 2'd1, 0, "R8 not counting");
        peek(2'd1, "R8 holds when disabled", 16'h0007);

        // R9 write and trigger together
        wr_reg(2'd0, 16'h0003, "R8 count on");
        step(req_pin, 1'b1, 0, 2'd1, 0, "R9 pre");
        step(req_pin, 1'b1, 1'b1, 2'd1, 16'h0004, "R9 write with trigger");
        peek(2'd1, "R9 trigger after clear", 16'h0105);

        // R10 map
        wr_reg(2'd0, 16'hFFFF, "R10 cfg all ones");
        peek(2'd0, "R10 cfg reads low bits only", 16'h0007);
        exp_ts = m_ts;
        wr_reg(2'd2, 16'hA5A5, "R10 ts low write");
        wr_reg(2'd3, 16'h5A5A, "R10 ts high write");
        peek(2'd2, "R10 ts low read-only", exp_ts[15:0]);
        peek(2'd3, "R10 ts high read-only", exp_ts[31:16]);

        // random mix against the model
        for (int i = 0; i < 4000; i++) begin
            logic pin, pps, wr;
            logic [1:0] a;
            logic [15:0] wd;
            pin = (($urandom % 5) == 0) ? ~req_pin : req_pin;
            pps = (($urandom % 7) == 0);
            wr  = (($urandom % 6) == 0);
            a   = 2'($urandom);
            wd  = 16'($urandom);
            if (($urandom % 3) == 0) wd[0] = 1'b0;
            step(pin, pps, wr, a, wd, "R10 random read-back");
        end

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule